// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a 32-bit processor core that fetches, decodes and executes exactly one instruction in every clock cycle. It covers a small load/store subset: word load and store, register-to-register add, subtract, bitwise and, bitwise or, signed set-on-less-than, branch-if-equal and an absolute jump. Instruction and data storage are two separate word arrays inside the block. Neither array is shared, so fetch and data access never compete within a cycle.

The arrays are filled through a plain valid/ready load port before the core runs. The ready signal is high only while reset is held. A word is written on a clock edge where valid and ready are both high. While the core runs, ready is low and anything offered is back-pressured forever and never lands. Once reset drops, the program counter starts at address 0.

Decoding happens in two stages. A main decoder turns the 6-bit opcode into datapath steering lines and a 2-bit ALU class. A second decoder turns that class, plus the function field for register-to-register operations, into a 3-bit ALU select. Debug outputs show the address of the instruction in flight, together with the register-file and data-memory writes it will commit at the next edge.

Top module: `sc_core`

## Requirements
- R1: `load_ready` equals `rst`. When `load_valid && load_ready` holds at a rising edge, `load_data` is written at word index `load_addr`. The write goes to instruction storage when `load_target`=0 and to data storage when `load_target`=1. An offer made while `rst` is low changes nothing.
- R2: Reset is synchronous and active high. While `rst` is high, the PC is 0 and no register-file or data-memory write takes place.
- R3: Instruction fields are: opcode in [31:26], first source register in [25:21], second source register in [20:16], destination register in [15:11], function code in [5:0] and a 16-bit signed immediate in [15:0]. Register-to-register instructions use opcode 000000 and write the register in [15:11]. Loads use opcode 100011 and write the register in [20:16].
- R4: For opcode 000000, the function code selects the ALU operation: 100000 is add, 100010 is subtract, 100100 is and, 100101 is or, and 101010 is signed set-on-less-than, which writes 1 or 0. Overflow is ignored.
- R5: Loads (100011) and stores (101011) use the byte address rs + sign-extended immediate. A store writes register [20:16] to data storage. A later load from the same address returns that value.
- R6: Branch-if-equal uses opcode 000100. When the two source registers are equal, the next PC is PC+4 + (sign-extended immediate << 2). Otherwise the next PC is PC+4.
- R7: Jump uses opcode 000010. The next PC is {PC+4 [31:28], instr[25:0], 2'b00}. A jump takes precedence over any branch selection. Every other instruction goes to PC+4.
- R8: Register 0 always reads as zero, and a write aimed at it is dropped. `dbg_rf_we` stays low for such a write.
- R9: `dbg_pc` is the address of the instruction executing this cycle. `dbg_rf_we`, `dbg_rf_waddr` and `dbg_rf_wdata` describe the register write that the instruction commits at the next edge. `dbg_dm_we`, `dbg_dm_addr` and `dbg_dm_wdata` do the same for a data-memory store.
- R10: Loads and stores drive the ALU with add, and branch-if-equal drives it with subtract, whatever the function field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | Preload word offered |
| load_ready | output | 1 | Preload accepted (high only in reset) |
| load_target | input | 1 | 0 = instruction storage, 1 = data storage |
| load_addr | input | LAW (6) | Word index for the preload |
| load_data | input | 32 | Preload word |
| dbg_pc | output | 32 | Address of the executing instruction |
| dbg_rf_we | output | 1 | Register write committed at next edge |
| dbg_rf_waddr | output | 5 | Destination register |
| dbg_rf_wdata | output | 32 | Value written to the register |
| dbg_dm_we | output | 1 | Data store committed at next edge |
| dbg_dm_addr | output | 32 | Byte address of the store |
| dbg_dm_wdata | output | 32 | Stored value |

## Verification
The hardest cases to reach from the ports are the ones that need earlier state to be in place. A store-then-load round trip needs both address and data registers already loaded. A negative-offset store needs a base that points above the target word. A taken branch must have both its operands equal. A backward branch must lead into a self-loop that halts the program.

The preloaded program is built so that each of these happens in a fixed order. Every register write and store is pushed into a scoreboard. Any write to register 0 appears as a missing debug event. Skipped instructions would show up as extra events.

A word is offered on the load port while the core runs. It targets the halt loop's own address, so an accepted word would produce a visible stray register write.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_cls_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_sel_e;

  typedef struct packed {
    logic     dst_rd;
    logic     src_imm;
    logic     wb_mem;
    logic     reg_write;
    logic     mem_read;
    logic     mem_write;
    logic     branch;
    logic     jump;
    alu_cls_e alu_cls;
  } ctrl_t;

endpackage

// File: rtl/sc_main_ctrl.sv
module sc_main_ctrl
  import sc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.alu_cls = CLS_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd    = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.alu_cls   = CLS_FUNCT;
      end
      OP_LOAD: begin
        ctrl.src_imm   = 1'b1;
        ctrl.wb_mem    = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.mem_read  = 1'b1;
      end
      OP_STORE: begin
        ctrl.src_imm   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch  = 1'b1;
        ctrl.alu_cls = CLS_SUB;
      end
      OP_JUMP: begin
        ctrl.jump = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

  AST_ONE_EFFECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.reg_write, ctrl.mem_write, ctrl.branch, ctrl.jump})); // R3

endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
  import sc_pkg::*;
(
  input  alu_cls_e   alu_cls,
  input  logic [5:0] funct,
  output alu_sel_e   alu_sel
);

  always_comb begin
    unique case (alu_cls)
      CLS_ADD: alu_sel = ALU_ADD;
      CLS_SUB: alu_sel = ALU_SUB;
      CLS_FUNCT: begin
        unique case (funct)
          FN_ADD:  alu_sel = ALU_ADD;
          FN_SUB:  alu_sel = ALU_SUB;
          FN_AND:  alu_sel = ALU_AND;
          FN_OR:   alu_sel = ALU_OR;
          FN_SLT:  alu_sel = ALU_SLT;
          default: alu_sel = ALU_ADD;
        endcase
      end
      default: alu_sel = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_sel_e       sel,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y,
  output logic           zero
);

  always_comb begin
    unique case (sel)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (raddr_a == '0) |-> (rdata_a == '0)); // R8
  AST_R0_KEEP: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == '0 && raddr_b == '0) |=> (raddr_b != '0 || rdata_b == '0)); // R8

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_valid,
  output logic            load_ready,
  input  logic            load_target,
  input  logic [LAW-1:0]  load_addr,
  input  logic [31:0]     load_data,
  output logic [31:0]     dbg_pc,
  output logic            dbg_rf_we,
  output logic [4:0]      dbg_rf_waddr,
  output logic [31:0]     dbg_rf_wdata,
  output logic            dbg_dm_we,
  output logic [31:0]     dbg_dm_addr,
  output logic [31:0]     dbg_dm_wdata
);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc, pc_next, pc_plus4, br_target, jmp_target;
  logic [XLEN-1:0] instr, imm_ext;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, mem_rdata, wb_data;
  logic [RAW-1:0]  dst_reg;
  logic            alu_zero, take_branch, rf_we, dm_we, load_fire;
  ctrl_t           ctrl;
  alu_sel_e        alu_sel;

  // ---------------- preload port ----------------
  assign load_ready = rst;
  assign load_fire  = load_valid && load_ready;

  always_ff @(posedge clk) begin
    if (load_fire && !load_target) imem[load_addr[IAW-1:0]] <= load_data;
  end

  // ---------------- fetch ----------------
  assign instr = imem[pc[IAW+1:2]];

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  // ---------------- decode ----------------
  sc_main_ctrl u_main_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (instr[31:26]),
    .ctrl   (ctrl)
  );

  sc_alu_ctrl u_alu_ctrl (
    .alu_cls (ctrl.alu_cls),
    .funct   (instr[5:0]),
    .alu_sel (alu_sel)
  );

  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign dst_reg = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_we   = ctrl.reg_write && !rst;

  sc_regfile #(.W(XLEN), .NREG(NREG)) u_regfile (
    .clk     (clk),
    .rst     (rst),
    .raddr_a (instr[25:21]),
    .raddr_b (instr[20:16]),
    .rdata_a (rs_val),
    .rdata_b (rt_val),
    .we      (rf_we),
    .waddr   (dst_reg),
    .wdata   (wb_data)
  );

  // ---------------- execute ----------------
  assign alu_b = ctrl.src_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .sel  (alu_sel),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // ---------------- data memory ----------------
  assign dm_we     = ctrl.mem_write && !rst;
  assign mem_rdata = ctrl.mem_read ? dmem[alu_y[DAW+1:2]] : '0;

  always_ff @(posedge clk) begin
    if (load_fire && load_target)  dmem[load_addr[DAW-1:0]] <= load_data;
    else if (dm_we)                dmem[alu_y[DAW+1:2]]     <= rt_val;
  end

  assign wb_data = ctrl.wb_mem ? mem_rdata : alu_y;

  // ---------------- next PC ----------------
  assign pc_plus4    = pc + 32'd4;
  assign br_target   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign take_branch = ctrl.branch && alu_zero;

  always_comb begin
    if (ctrl.jump)        pc_next = jmp_target;
    else if (take_branch) pc_next = br_target;
    else                  pc_next = pc_plus4;
  end

  // ---------------- debug ----------------
  assign dbg_pc       = pc;
  assign dbg_rf_we    = rf_we && (dst_reg != '0);
  assign dbg_rf_waddr = dst_reg;
  assign dbg_rf_wdata = wb_data;
  assign dbg_dm_we    = dm_we;
  assign dbg_dm_addr  = alu_y;
  assign dbg_dm_wdata = rt_val;

  // ---------------- assertions ----------------
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !take_branch) |=> (pc == $past(pc) + 32'd4)); // R7
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    (take_branch && !ctrl.jump) |=> (pc == $past(pc) + 32'd4 + {$past(imm_ext[XLEN-3:0]), 2'b00})); // R6
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> (pc[27:0] == {$past(instr[25:0]), 2'b00})); // R7
  AST_MEM_USES_ADD: assert property (@(posedge clk) disable iff (rst)
    (ctrl.mem_read || ctrl.mem_write) |-> (alu_sel == ALU_ADD)); // R10
  AST_BRANCH_USES_SUB: assert property (@(posedge clk) disable iff (rst)
    ctrl.branch |-> (alu_sel == ALU_SUB)); // R10
  AST_LOAD_BLOCKED_RUN: assert property (@(posedge clk)
    !rst |-> !load_ready); // R1

endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb;

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic        load_target = 1'b0;
  logic [5:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] dbg_pc, dbg_rf_wdata, dbg_dm_addr, dbg_dm_wdata;
  logic [4:0]  dbg_rf_waddr;
  logic        dbg_rf_we, dbg_dm_we;

  int errors = 0;
  int checks = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;

  exp_t pc_q[$];
  exp_t rf_q[$];
  exp_t dm_q[$];

  always #2.5 clk = ~clk;

  sc_core u_dut (
    .clk(clk), .rst(rst),
    .load_valid(load_valid), .load_ready(load_ready), .load_target(load_target),
    .load_addr(load_addr), .load_data(load_data),
    .dbg_pc(dbg_pc), .dbg_rf_we(dbg_rf_we), .dbg_rf_waddr(dbg_rf_waddr),
    .dbg_rf_wdata(dbg_rf_wdata), .dbg_dm_we(dbg_dm_we),
    .dbg_dm_addr(dbg_dm_addr), .dbg_dm_wdata(dbg_dm_wdata)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] idx);
    return {6'b000010, idx};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preload(logic tgt, int idx, logic [31:0] w);
    @(negedge clk);
    load_valid  = 1'b1;
    load_target = tgt;
    load_addr   = 6'(idx);
    load_data   = w;
    @(negedge clk);
    load_valid  = 1'b0;
  endtask

  task automatic exp_pc(logic [31:0] p, string tag);
    pc_q.push_back('{a: p, d: '0, tag: tag});
  endtask
  task automatic exp_rf(int r, logic [31:0] v, string tag);
    rf_q.push_back('{a: 32'(r), d: v, tag: tag});
  endtask
  task automatic exp_dm(logic [31:0] addr, logic [31:0] v, string tag);
    dm_q.push_back('{a: addr, d: v, tag: tag});
  endtask

  // monitor: compare design activity against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (mon_en) begin
        exp_t e;
        if (pc_q.size() > 0) begin
          e = pc_q.pop_front();
          check({e.tag, " pc"}, dbg_pc, e.a);
        end else begin
          check("R6 halt loop pc", dbg_pc, 32'h50);
        end
        if (dbg_rf_we) begin
          if (rf_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R9 unexpected reg write: actual=r%0d/%h expected=none",
                     dbg_rf_waddr, dbg_rf_wdata);
          end else begin
            e = rf_q.pop_front();
            check({e.tag, " dest"}, 32'(dbg_rf_waddr), e.a);
            check({e.tag, " value"}, dbg_rf_wdata, e.d);
          end
        end
        if (dbg_dm_we) begin
          if (dm_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R9 unexpected store: actual=%h/%h expected=none",
                     dbg_dm_addr, dbg_dm_wdata);
          end else begin
            e = dm_q.pop_front();
            check({e.tag, " store addr"}, dbg_dm_addr, e.a);
            check({e.tag, " store data"}, dbg_dm_wdata, e.d);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // driver
  initial begin
    logic [31:0] prog [22];
    prog[0]  = enc_i(6'h23, 0, 1, 16'd0);        // lw r1,0(r0)
    prog[1]  = enc_i(6'h23, 0, 2, 16'd4);        // lw r2,4(r0)
    prog[2]  = enc_r(1, 2, 3, 6'b100000);        // add r3
    prog[3]  = enc_r(1, 2, 4, 6'b100010);        // sub r4
    prog[4]  = enc_r(1, 2, 5, 6'b100100);        // and r5
    prog[5]  = enc_r(1, 2, 6, 6'b100101);        // or r6
    prog[6]  = enc_r(2, 1, 7, 6'b101010);        // slt r7 = (-3<5)
    prog[7]  = enc_r(1, 2, 8, 6'b101010);        // slt r8 = (5<-3)
    prog[8]  = enc_i(6'h2B, 3, 4, 16'd6);        // sw r4,6(r3)
    prog[9]  = enc_i(6'h2B, 4, 7, 16'hFFFC);     // sw r7,-4(r4)
    prog[10] = enc_r(1, 1, 0, 6'b100000);        // add r0 (dropped)
    prog[11] = enc_r(0, 1, 9, 6'b100000);        // add r9 = r0+r1
    prog[12] = enc_i(6'h04, 1, 2, 16'd5);        // beq not taken
    prog[13] = enc_i(6'h04, 5, 1, 16'd2);        // beq taken -> 0x40
    prog[14] = enc_r(1, 1, 10, 6'b100000);       // skipped
    prog[15] = enc_r(1, 1, 10, 6'b100000);       // skipped
    prog[16] = enc_i(6'h23, 0, 11, 16'd8);       // lw r11,8(r0)
    prog[17] = enc_j(26'h14);                    // j 0x50
    prog[18] = enc_r(1, 1, 12, 6'b100000);       // skipped
    prog[19] = enc_r(1, 1, 12, 6'b100000);       // skipped
    prog[20] = enc_i(6'h04, 0, 0, 16'hFFFF);     // beq r0,r0,-1 halt
    prog[21] = 32'd0;

    repeat (2) @(negedge clk);
    check("R1 ready in reset", 32'(load_ready), 32'd1);
    for (int i = 0; i < 22; i++) preload(1'b0, i, prog[i]);
    preload(1'b1, 0, 32'd5);
    preload(1'b1, 1, 32'hFFFF_FFFD);
    preload(1'b1, 2, 32'd12);

    // expected PC trace
    for (int i = 0; i < 14; i++) exp_pc(32'(i * 4), "R7 sequential");
    exp_pc(32'h40, "R6 branch taken");
    exp_pc(32'h44, "R5 reload");
    exp_pc(32'h50, "R7 jump");
    exp_pc(32'h50, "R6 backward branch");

    // expected register writes
    exp_rf(1, 32'd5, "R5 load r1");
    exp_rf(2, 32'hFFFF_FFFD, "R5 load r2");
    exp_rf(3, 32'd2, "R4 add");
    exp_rf(4, 32'd8, "R4 sub");
    exp_rf(5, 32'd5, "R4 and");
    exp_rf(6, 32'hFFFF_FFFD, "R4 or");
    exp_rf(7, 32'd1, "R4 slt signed true");
    exp_rf(8, 32'd0, "R4 slt signed false");
    exp_rf(9, 32'd5, "R8 r0 read zero");
    exp_rf(11, 32'd8, "R5 store-load round trip");

    // expected stores
    exp_dm(32'd8, 32'd8, "R5 store positive offset");
    exp_dm(32'd4, 32'd1, "R5 store negative offset");

    // reset state
    @(negedge clk);
    #1;
    check("R2 pc in reset", dbg_pc, 32'd0);
    check("R2 no reg write in reset", 32'(dbg_rf_we), 32'd0);
    check("R2 no store in reset", 32'(dbg_dm_we), 32'd0);
    @(negedge clk);
    rst    = 1'b0;
    mon_en = 1'b1;

    // offer a word while running: it must never land (R1)
    @(negedge clk);
    load_valid  = 1'b1;
    load_target = 1'b0;
    load_addr   = 6'd20;
    load_data   = enc_r(1, 1, 13, 6'b100000);
    #1;
    check("R1 ready low while running", 32'(load_ready), 32'd0);
    @(negedge clk);
    load_valid = 1'b0;

    repeat (24) @(negedge clk);
    #2;
    mon_en = 1'b0;
    check("R9 all pcs seen", 32'(pc_q.size()), 32'd0);
    check("R9 all reg writes seen (R3 dest select)", 32'(rf_q.size()), 32'd0);
    check("R9 all stores seen", 32'(dm_q.size()), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule